// File: doc/BRIEF.md
# Serial Conversion-Start Command Front End

This block sits between a four-wire serial link (mode 0: data sampled on the rising clock edge, returned on the falling edge, most significant bit first) and an analog-to-digital converter. It holds an 8-bit channel-select register. The upper nibble chooses the positive input and the lower nibble chooses the negative input. The first byte of every transfer is a header: a direction bit, a register address, and a start flag. A transfer to the channel-select address writes the register or reads it back. When the start flag is set, the same transfer also launches a conversion.

Start requests are raised in the serial clock domain and carried into the system clock domain by a toggle and a synchronizer. There a sequencer counts modulator conversion ticks. It withholds data validity until the filter has settled, then runs either one shot or continuously. While the start is pending it raises a busy bit. The analog multiplexer is driven from the register. It is reported open when the converter is powered down or when the code selects no input.

Top module: `adc_cmd_front`

## Requirements
- R1: After reset the channel register is 0x00, strt_busy, data_valid, conv_start and data_load are 0, and miso is 0.
- R2: Header bit 7 is the direction (1 = read, 0 = write), bits 6:1 are the address (MUX_ADDR, default 1) and bit 0 is the start flag; a transfer to any other address changes nothing.
- R3: A write shifts 8 data bits MSB first; the register takes the byte at the 16th rising SCLK edge (bits 7:4 positive code, bits 3:0 negative code); raising cs_n before that edge discards the write.
- R4: A read drives the register onto miso MSB first, changing on falling SCLK edges so that rising edges 9 to 16 see bits 7 to 0; miso is 0 whenever cs_n is high or no read is in progress.
- R5: A write with the start flag launches a conversion only after the data byte is taken, so the new channel selection is already in place when conv_start pulses.
- R6: A read with the start flag launches a conversion at the 8th rising SCLK edge; raising cs_n during the data phase does not cancel it and leaves the register unchanged.
- R7: A write without the start flag changes the selection but leaves strt_busy, data_valid and the running conversion sequence untouched.
- R8: conv_start is a one-cycle pulse; after it, data_valid is 0 and data_load stays low until the SETTLE-th (default 4th) completed conversion, which sets data_valid and pulses data_load.
- R9: One conversion completes every rate+1 conversion ticks.
- R10: With cont_en=0 the converter stops after the first valid conversion; with cont_en=1 every further conversion pulses data_load until cont_en or adc_en is cleared.
- R11: strt_busy is set by a start and clears when the first valid conversion completes, or when adc_en drops.
- R12: pos_open is 1 when adc_en=0 or the positive code is 11xx; neg_open is 1 when adc_en=0 or the negative code is 1101 or 111x.
- R13: A start request while adc_en=0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low transfer select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| conv_tick | input | 1 | One-cycle modulator conversion tick |
| cont_en | input | 1 | Continuous conversion mode |
| adc_en | input | 1 | Converter power enable |
| rate | input | RATE_W | Ticks per conversion minus one |
| pos_sel | output | 4 | Positive input code |
| neg_sel | output | 4 | Negative input code |
| pos_open | output | 1 | Positive input open |
| neg_open | output | 1 | Negative input open |
| conv_start | output | 1 | Start pulse, also clears the filter |
| data_load | output | 1 | Load pulse for the data register |
| data_valid | output | 1 | Data register holds settled data |
| strt_busy | output | 1 | Start pending status |

## Verification
The channel outputs follow the 16th rising SCLK edge combinationally, so the bench checks them only after the transfer has ended. Read data is captured just before each rising SCLK edge, when the bit driven on the preceding falling edge is stable. A start crosses three system flops, and conv_start appears three to four clocks after the SCLK edge that raised it. The bench therefore waits several clocks after cs_n rises before it checks the start count and strt_busy. Each tick is held for one clock between falling edges, and data_load and data_valid are read at the falling edge that ends the tick, one register stage after it.

// File: rtl/adc_cmd_front.sv
module adc_cmd_front #(
  parameter logic [5:0] MUX_ADDR = 6'h01,
  parameter int SETTLE = 4,
  parameter int RATE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              miso,
  input  logic              conv_tick,
  input  logic              cont_en,
  input  logic              adc_en,
  input  logic [RATE_W-1:0] rate,
  output logic [3:0]        pos_sel,
  output logic [3:0]        neg_sel,
  output logic              pos_open,
  output logic              neg_open,
  output logic              conv_start,
  output logic              data_load,
  output logic              data_valid,
  output logic              strt_busy
);
  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SETTLE);

  logic [4:0] bcnt;
  logic [7:0] sh, hdr, tx, mux_q;
  logic req_t, sclr;
  logic [7:0] nxt;

  assign sclr = cs_n | ~rst_n;
  assign nxt  = {sh[6:0], mosi};

  wire hdr_wr = (hdr[7:1] == {1'b0, MUX_ADDR});
  wire hdr_rd = (hdr[7:1] == {1'b1, MUX_ADDR});

  always_ff @(posedge sclk or posedge sclr) begin
    if (sclr) begin
      bcnt <= '0;
      sh   <= '0;
      hdr  <= '0;
    end else begin
      sh <= nxt;
      if (bcnt != 5'd16) bcnt <= bcnt + 5'd1;
      if (bcnt == 5'd7) hdr <= nxt;
    end
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q <= '0;
      req_t <= 1'b0;
    end else if (!cs_n) begin
      if (bcnt == 5'd7 && nxt[7:1] == {1'b1, MUX_ADDR} && nxt[0]) req_t <= ~req_t;
      if (bcnt == 5'd15 && hdr_wr) begin
        mux_q <= nxt;
        if (hdr[0]) req_t <= ~req_t;
      end
    end
  end

  always_ff @(negedge sclk or posedge sclr) begin
    if (sclr) tx <= '0;
    else if (bcnt == 5'd8 && hdr_rd) tx <= mux_q;
    else tx <= {tx[6:0], 1'b0};
  end

  assign miso     = tx[7];
  assign pos_sel  = mux_q[7:4];
  assign neg_sel  = mux_q[3:0];
  assign pos_open = ~adc_en | (pos_sel[3:2] == 2'b11);
  assign neg_open = ~adc_en | (neg_sel == 4'hD) | (neg_sel[3:1] == 3'b111);

  logic [2:0] sync;
  logic active, strt, valid, start_q, load_q;
  logic [CNT_W-1:0] nconv;
  logic [RATE_W-1:0] dcnt;

  wire start_ev = sync[2] ^ sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else sync <= {sync[1:0], req_t};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      strt    <= 1'b0;
      valid   <= 1'b0;
      start_q <= 1'b0;
      load_q  <= 1'b0;
      nconv   <= '0;
      dcnt    <= '0;
    end else begin
      start_q <= 1'b0;
      load_q  <= 1'b0;
      if (!adc_en) begin
        active <= 1'b0;
        strt   <= 1'b0;
      end else if (start_ev) begin
        active  <= 1'b1;
        strt    <= 1'b1;
        valid   <= 1'b0;
        nconv   <= '0;
        dcnt    <= '0;
        start_q <= 1'b1;
      end else if (active && conv_tick) begin
        if (dcnt == rate) begin
          dcnt <= '0;
          if (nconv != FULL) nconv <= nconv + CNT_W'(1);
          if (nconv >= LAST) begin
            load_q <= 1'b1;
            valid  <= 1'b1;
            strt   <= 1'b0;
            if (!cont_en) active <= 1'b0;
          end
        end else begin
          dcnt <= dcnt + RATE_W'(1);
        end
      end
    end
  end

  assign conv_start = start_q;
  assign data_load  = load_q;
  assign data_valid = valid;
  assign strt_busy  = strt;
endmodule

module adc_cmd_front_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic miso,
  input logic adc_en,
  input logic pos_open,
  input logic neg_open,
  input logic conv_start,
  input logic data_load,
  input logic data_valid,
  input logic strt_busy
);
  assert_load_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_load |-> data_valid);
  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  assert_start_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (strt_busy && !data_valid));
  assert_load_clears_strt_R11: assert property (@(posedge clk) disable iff (!rst_n)
    data_load |-> !strt_busy);
  assert_strt_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strt_busy) |-> (data_valid || !$past(adc_en)));
  assert_off_open_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |-> (pos_open && neg_open));
  assert_idle_miso_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !miso);
endmodule

bind adc_cmd_front adc_cmd_front_chk chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .adc_en(adc_en),
  .pos_open(pos_open), .neg_open(neg_open), .conv_start(conv_start),
  .data_load(data_load), .data_valid(data_valid), .strt_busy(strt_busy)
);

// File: tb/adc_cmd_front_test.sv
module adc_cmd_front_test;
  logic clk = 0, rst_n = 0, sclk = 0, cs_n = 1, mosi = 0, conv_tick = 0;
  logic cont_en = 0, adc_en = 1;
  logic [2:0] rate = 0;
  logic miso, pos_open, neg_open, conv_start, data_load, data_valid, strt_busy;
  logic [3:0] pos_sel, neg_sel;
  int checks = 0, errors = 0, nstart = 0;
  logic [7:0] rd;
  logic ld;

  adc_cmd_front uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .conv_tick(conv_tick), .cont_en(cont_en), .adc_en(adc_en), .rate(rate),
    .pos_sel(pos_sel), .neg_sel(neg_sel), .pos_open(pos_open), .neg_open(neg_open),
    .conv_start(conv_start), .data_load(data_load), .data_valid(data_valid),
    .strt_busy(strt_busy)
  );

  always #5 clk = ~clk;
  always @(negedge clk) if (conv_start) nstart++;

  // {register value, positive open, negative open}
  localparam logic [9:0] VEC [0:8] = '{
    {8'h12, 1'b0, 1'b0}, {8'h9A, 1'b0, 1'b0}, {8'hB7, 1'b0, 1'b0},
    {8'hC0, 1'b1, 1'b0}, {8'h3D, 1'b0, 1'b1}, {8'h5E, 1'b0, 1'b1},
    {8'h8F, 1'b0, 1'b1}, {8'hFC, 1'b1, 1'b0}, {8'hA9, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] h, input logic [7:0] d, input int nbits,
                      output logic [7:0] r);
    r = 8'h00;
    @(negedge clk);
    cs_n = 0;
    #20;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? h[7-i] : d[15-i];
      #20;
      if (i >= 8) r[15-i] = miso;
      sclk = 1;
      #20;
      sclk = 0;
    end
    #20 cs_n = 1;
    mosi = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic tick(output logic l);
    @(negedge clk) conv_tick = 1;
    @(negedge clk) conv_tick = 0;
    l = data_load;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reg", {pos_sel, neg_sel}, 8'h00);
    chk("R1 status", {strt_busy, data_valid, conv_start, data_load, miso}, 5'b0);

    foreach (VEC[k]) begin
      xfer(8'h02, VEC[k][9:2], 16, rd);
      chk("R3 write", {pos_sel, neg_sel}, VEC[k][9:2]);
      chk("R12 open", {pos_open, neg_open}, VEC[k][1:0]);
      xfer(8'h82, 8'h00, 16, rd);
      chk("R4 readback", rd, VEC[k][9:2]);
    end
    chk("R7 no start from plain writes", nstart, 0);

    xfer(8'h0A, 8'hFF, 16, rd);
    chk("R2 other address ignored", {pos_sel, neg_sel}, 8'hA9);
    xfer(8'h02, 8'h33, 12, rd);
    chk("R3 aborted write", {pos_sel, neg_sel}, 8'hA9);

    adc_en = 0;
    @(negedge clk);
    chk("R12 powered down", {pos_open, neg_open}, 2'b11);
    xfer(8'h03, 8'h45, 16, rd);
    chk("R13 start ignored", {nstart[7:0], strt_busy}, 9'h0);
    adc_en = 1;

    xfer(8'h03, 8'h45, 16, rd);
    chk("R5 start on write", nstart, 1);
    chk("R5 selection applied", {pos_sel, neg_sel}, 8'h45);
    chk("R11 busy set", {strt_busy, data_valid}, 2'b10);
    for (int k = 1; k <= 3; k++) begin
      tick(ld);
      chk("R8 unsettled", {ld, data_valid}, 2'b00);
    end
    tick(ld);
    chk("R8 fourth conversion", {ld, data_valid}, 2'b11);
    chk("R11 busy cleared", strt_busy, 0);
    tick(ld);
    chk("R10 single shot stops", ld, 0);

    cont_en = 1;
    rate = 3'd2;
    xfer(8'h83, 8'h00, 10, rd);
    chk("R6 read start aborted", nstart, 2);
    chk("R6 register kept", {pos_sel, neg_sel, strt_busy}, {8'h45, 1'b1});
    for (int k = 1; k <= 12; k++) begin
      tick(ld);
      chk("R9 settle with rate", ld, (k == 12));
    end
    for (int k = 1; k <= 3; k++) begin
      tick(ld);
      chk("R10 continuous", ld, (k == 3));
    end
    s0 = nstart;
    xfer(8'h02, 8'h21, 16, rd);
    chk("R7 selection", {pos_sel, neg_sel}, 8'h21);
    chk("R7 state kept", {nstart == s0, strt_busy, data_valid}, 3'b101);
    for (int k = 1; k <= 3; k++) begin
      tick(ld);
      chk("R7 still running", ld, (k == 3));
    end

    cont_en = 0;
    for (int k = 1; k <= 6; k++) begin
      tick(ld);
      chk("R10 stop on cont clear", ld, (k == 3));
    end

    cont_en = 1;
    rate = 3'd0;
    xfer(8'h83, 8'h00, 16, rd);
    chk("R4 read with start data", rd, 8'h21);
    tick(ld);
    tick(ld);
    adc_en = 0;
    @(negedge clk);
    chk("R11 power down clears busy", strt_busy, 0);
    adc_en = 1;
    for (int k = 1; k <= 4; k++) begin
      tick(ld);
      chk("R10 stopped by adc_en", ld, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule